// File: doc/BRIEF.md
# Two-Stage Countdown Watchdog

This block is a watchdog timer that sits behind a small word-wide register bus. A divider turns the core clock into coarse ticks, and a 10-bit counter steps down once per tick from a value that software programs. Software proves it is alive by writing the reload register. Each write puts the counter back to the programmed start value and restarts the tick divider.

If software misses its deadline, the first expiry raises a timeout flag. It can also pulse a system-management interrupt, so firmware gets a chance to recover. The counter then starts a new period. If a second expiry arrives while the timeout flag is still set, the block records a second-timeout flag and a boot-status flag. It then drives a fixed-length system reset pulse, unless the external no-reboot input holds that pulse back.

A halt bit freezes the count and comes out of reset set, so the watchdog stays idle until software releases it. The tick length, the reset-pulse length and the start value after reset are all parameters. A test environment can therefore use very short ticks.

Top module: `wdt_top`

## Requirements
- R1: After reset the halt bit (bit 11 at offset 0x08) reads 1, offset 0x12 reads DEF_INIT, offset 0x00 reads DEF_INIT, offsets 0x04 and 0x06 read 0, and both smi_irq and sys_rst_out are low.
- R2: A write of any data to offset 0x00 loads the counter with the stored start value and restarts the tick divider. A read of offset 0x00 returns the counter in bits [9:0], with bits [15:10] reading 0.
- R3: While the halt bit is 0, the counter drops by one on every TICK_CYCLES-th clock. While the halt bit is 1, the counter and the divider hold their values.
- R4: The start value sits in bits [9:0] of offset 0x12. A write whose bits [9:0] are below 4 leaves the stored value unchanged. Bits [15:10] of offset 0x12 always read 0, whatever was written to them.
- R5: An expiry happens on a tick that finds the counter at 0. The counter then reloads the stored start value and keeps counting.
- R6: On an expiry while the timeout flag (bit 3 at offset 0x04) is 0, that flag is set. If the interrupt enable (bit 13 at offset 0x0C) is 1, smi_irq is high for exactly one cycle, in the same cycle the flag first reads 1.
- R7: On an expiry while the timeout flag is 1, the block sets the second-timeout flag (bit 1 at offset 0x06) and the boot flag (bit 2 at offset 0x06). It also drives sys_rst_out high for RST_CYCLES consecutive cycles, unless no_reboot is 1 in the expiry cycle, in which case sys_rst_out stays low.
- R8: Writing 1 to a flag bit clears that flag. Writing 0 leaves it as it was. A flag that is set and cleared in the same cycle ends up set.
- R9: A reload write in the same cycle as a tick takes priority. No expiry happens, and the counter takes the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| no_reboot | input | 1 | When high, a second expiry does not start a reset pulse |
| smi_irq | output | 1 | One-cycle interrupt pulse on a first expiry |
| sys_rst_out | output | 1 | System reset pulse after a second expiry |

## Verification
The bench aims at the cycle where a reload write lands exactly on the expiring tick. A design that let the expiry win would raise a timeout flag during keepalive patterns that are still legal. It also holds a write-one-to-clear on the timeout flag across an expiry: a design that let the clear win would lose the first timeout and never escalate. Start values of 0 to 3 and junk in the upper bits of the start register are written to catch a counter that could be set to expire almost at once. The reset pulse is timed for its exact width, and a run with no_reboot high confirms that the flags still escalate while the pulse stays off.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    localparam int CNT_W    = 10;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int MIN_INIT = 4;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT1  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT2  = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_GATE   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_INIT   = 5'h12;

    // field positions
    localparam int BIT_TO    = 3;
    localparam int BIT_SEC   = 1;
    localparam int BIT_BOOT  = 2;
    localparam int BIT_HALT  = 11;
    localparam int BIT_SMIEN = 13;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    typedef enum logic [1:0] {
        EXP_NONE   = 2'd0,
        EXP_FIRST  = 2'd1,
        EXP_SECOND = 2'd2
    } exp_kind_t;

    function automatic logic init_legal(input logic [CNT_W-1:0] v);
        return v >= CNT_W'(MIN_INIT);
    endfunction

    function automatic logic wr_hit(input bus_req_t r, input logic [ADDR_W-1:0] a);
        return r.wr && (r.addr == a);
    endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
`timescale 1ns/1ps
module wdt_tick_gen #(
    parameter int TICK_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign tick = run && (phase_q == LAST);

endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int DEF_INIT = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= CNT_W'(DEF_INIT);
        end else if (reload) begin
            count <= init_val;
        end else if (tick) begin
            count <= (count == '0) ? init_val : count - 1'b1;
        end
    end

    // a reload in the same cycle cancels the expiry
    assign expire = tick && !reload && (count == '0);

endmodule

// File: rtl/wdt_ctrl_regs.sv
`timescale 1ns/1ps
module wdt_ctrl_regs
    import wdt_pkg::*;
#(
    parameter int DEF_INIT = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic             expire,
    output logic             halt,
    output logic             smi_en,
    output logic [CNT_W-1:0] init_val,
    output logic             to_flag,
    output logic             sec_flag,
    output logic             boot_flag,
    output logic             smi_irq,
    output exp_kind_t        kind
);
    logic unused_data_bits;
    assign unused_data_bits = ^{req.data[15:14], req.data[12], req.data[10]};

    always_comb begin
        if (!expire)      kind = EXP_NONE;
        else if (to_flag) kind = EXP_SECOND;
        else              kind = EXP_FIRST;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt     <= 1'b1;
            smi_en   <= 1'b0;
            init_val <= CNT_W'(DEF_INIT);
        end else begin
            if (wr_hit(req, OFS_CTRL)) halt   <= req.data[BIT_HALT];
            if (wr_hit(req, OFS_GATE)) smi_en <= req.data[BIT_SMIEN];
            if (wr_hit(req, OFS_INIT) && init_legal(req.data[CNT_W-1:0]))
                init_val <= req.data[CNT_W-1:0];
        end
    end

    // status flags: a set in the same cycle beats a write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst) begin
            to_flag   <= 1'b0;
            sec_flag  <= 1'b0;
            boot_flag <= 1'b0;
            smi_irq   <= 1'b0;
        end else begin
            smi_irq <= (kind == EXP_FIRST) && smi_en;
            if (kind == EXP_FIRST)
                to_flag <= 1'b1;
            else if (wr_hit(req, OFS_STAT1) && req.data[BIT_TO])
                to_flag <= 1'b0;
            if (kind == EXP_SECOND) begin
                sec_flag  <= 1'b1;
                boot_flag <= 1'b1;
            end else if (wr_hit(req, OFS_STAT2)) begin
                if (req.data[BIT_SEC])  sec_flag  <= 1'b0;
                if (req.data[BIT_BOOT]) boot_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdt_reset_stretch.sv
`timescale 1ns/1ps
module wdt_reset_stretch #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic sys_rst
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    logic [RW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= RW'(RST_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign sys_rst = (left_q != '0);

endmodule

// File: rtl/wdt_top.sv
`timescale 1ns/1ps
module wdt_top
    import wdt_pkg::*;
#(
    parameter int TICK_CYCLES = 1000,
    parameter int RST_CYCLES  = 16,
    parameter int DEF_INIT    = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              no_reboot,
    output logic              smi_irq,
    output logic              sys_rst_out
);
    bus_req_t         req;
    logic             reload_wr;
    logic             tick;
    logic             expire;
    logic             halt_q;
    logic             smi_en_q;
    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] count_q;
    logic             to_q;
    logic             sec_q;
    logic             boot_q;
    exp_kind_t        kind;

    assign req       = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};
    assign reload_wr = wr_hit(req, OFS_RELOAD);

    wdt_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (!halt_q),
        .restart (reload_wr),
        .tick    (tick)
    );

    wdt_countdown #(.DEF_INIT(DEF_INIT)) u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .reload   (reload_wr),
        .init_val (init_q),
        .count    (count_q),
        .expire   (expire)
    );

    wdt_ctrl_regs #(.DEF_INIT(DEF_INIT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .expire    (expire),
        .halt      (halt_q),
        .smi_en    (smi_en_q),
        .init_val  (init_q),
        .to_flag   (to_q),
        .sec_flag  (sec_q),
        .boot_flag (boot_q),
        .smi_irq   (smi_irq),
        .kind      (kind)
    );

    wdt_reset_stretch #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk     (clk),
        .rst     (rst),
        .fire    ((kind == EXP_SECOND) && !no_reboot),
        .sys_rst (sys_rst_out)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_RELOAD: bus_rdata[CNT_W-1:0] = count_q;
            OFS_STAT1:  bus_rdata[BIT_TO]    = to_q;
            OFS_STAT2: begin
                bus_rdata[BIT_SEC]  = sec_q;
                bus_rdata[BIT_BOOT] = boot_q;
            end
            OFS_CTRL:   bus_rdata[BIT_HALT]  = halt_q;
            OFS_GATE:   bus_rdata[BIT_SMIEN] = smi_en_q;
            OFS_INIT:   bus_rdata[CNT_W-1:0] = init_q;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_chk.sv
`timescale 1ns/1ps
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             no_reboot,
    input logic             reload_wr,
    input logic             halt_q,
    input logic             smi_irq,
    input logic             sys_rst_out,
    input logic             to_q,
    input logic             sec_q,
    input logic             boot_q,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] init_q
);
    logic [31:0] hi_run_q;

    always_ff @(posedge clk) begin
        if (rst)              hi_run_q <= '0;
        else if (sys_rst_out) hi_run_q <= hi_run_q + 1;
        else                  hi_run_q <= '0;
    end

    // R3
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_q && !reload_wr) |=> $stable(count_q));

    // R4
    init_floor_chk: assert property (@(posedge clk) disable iff (rst)
        init_q >= CNT_W'(MIN_INIT));

    // R9
    reload_load_chk: assert property (@(posedge clk) disable iff (rst)
        reload_wr |=> (count_q == $past(init_q)));

    // R6
    smi_flag_chk: assert property (@(posedge clk) disable iff (rst)
        smi_irq |-> to_q);

    // R6
    smi_single_chk: assert property (@(posedge clk) disable iff (rst)
        smi_irq |=> !smi_irq);

    // R7
    rst_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_out) |-> (sec_q && boot_q));

    // R7
    rst_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_out) |-> $past(!no_reboot));

    // R7
    rst_width_chk: assert property (@(posedge clk) disable iff (rst)
        hi_run_q <= 32'(RST_CYCLES));

endmodule

bind wdt_top wdt_chk #(.RST_CYCLES(RST_CYCLES)) u_wdt_chk (
    .clk         (clk),
    .rst         (rst),
    .no_reboot   (no_reboot),
    .reload_wr   (reload_wr),
    .halt_q      (halt_q),
    .smi_irq     (smi_irq),
    .sys_rst_out (sys_rst_out),
    .to_q        (to_q),
    .sec_q       (sec_q),
    .boot_q      (boot_q),
    .count_q     (count_q),
    .init_q      (init_q)
);

// File: tb/tb_wdt_top.sv
`timescale 1ns/1ps
module tb_wdt_top;
    localparam int TICK = 4;
    localparam int RSTN = 3;
    localparam int DEFI = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        no_reboot = 1'b0;
    wire  [15:0] bus_rdata;
    wire         smi_irq;
    wire         sys_rst_out;

    int checks = 0;
    int errors = 0;
    bit chk_on = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wdt_top #(.TICK_CYCLES(TICK), .RST_CYCLES(RSTN), .DEF_INIT(DEFI)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .no_reboot(no_reboot),
        .smi_irq(smi_irq), .sys_rst_out(sys_rst_out)
    );

    // behavioural reference
    int m_pc, m_cnt, m_init, m_halt, m_smien, m_to, m_sec, m_boot, m_smi, m_rcnt;

    always @(posedge clk) begin : model
        int a, d, n_pc, n_cnt;
        bit tick, rel, expd;
        if (rst) begin
            m_pc = 0; m_cnt = DEFI; m_init = DEFI; m_halt = 1; m_smien = 0;
            m_to = 0; m_sec = 0; m_boot = 0; m_smi = 0; m_rcnt = 0;
        end else begin
            a = bus_wr ? int'(bus_addr) : -1;
            d = int'(bus_wdata);
            tick = (m_halt == 0) && (m_pc == TICK - 1);
            rel  = (a == 0);
            expd = tick && (m_cnt == 0) && !rel;
            n_pc  = rel ? 0 : (m_halt == 0 ? (m_pc + 1) % TICK : m_pc);
            n_cnt = rel ? m_init : (tick ? (m_cnt == 0 ? m_init : m_cnt - 1) : m_cnt);
            m_smi = (expd && m_to == 0 && m_smien == 1) ? 1 : 0;
            if (expd && m_to == 1) begin
                m_sec = 1; m_boot = 1;
                m_rcnt = no_reboot ? (m_rcnt > 0 ? m_rcnt - 1 : 0) : RSTN;
            end else begin
                if (a == 6 && d[1]) m_sec = 0;
                if (a == 6 && d[2]) m_boot = 0;
                if (m_rcnt > 0) m_rcnt = m_rcnt - 1;
            end
            if (expd && m_to == 0) m_to = 1;
            else if (a == 4 && d[3]) m_to = 0;
            if (a == 8)  m_halt = d[11];
            if (a == 12) m_smien = d[13];
            if (a == 18 && (d % 1024) >= 4) m_init = d % 1024;
            m_pc = n_pc; m_cnt = n_cnt;
        end
    end

    function automatic int mread(input int a);
        case (a)
            0:  return m_cnt;
            4:  return m_to << 3;
            6:  return (m_boot << 2) | (m_sec << 1);
            8:  return m_halt << 11;
            12: return m_smien << 13;
            18: return m_init;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (chk_on && !rst) begin
            chk(smi_irq == (m_smi != 0), "R6 smi_irq vs model", int'(smi_irq), m_smi);
            chk(sys_rst_out == (m_rcnt != 0), "R7 sys_rst_out vs model", int'(sys_rst_out), int'(m_rcnt != 0));
            chk(int'(bus_rdata) == mread(int'(bus_addr)), "R3 bus_rdata vs model",
                int'(bus_rdata), mread(int'(bus_addr)));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); #0.2;
        bus_addr = 5'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
        @(negedge clk); #0.2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        @(negedge clk); #0.2;
        bus_addr = 5'(a);
        #0.2;
        chk(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int n, hi;
        bit seen;
        repeat (3) @(negedge clk);
        #0.2 rst = 1'b0;
        chk_on = 1;

        // R1 reset state
        rd(8, 16'h0800, "R1 halt after reset");
        rd(18, DEFI, "R1 start value after reset");
        rd(0, DEFI, "R1 count after reset");
        rd(4, 0, "R1 stat1 after reset");
        rd(6, 0, "R1 stat2 after reset");
        chk(!smi_irq && !sys_rst_out, "R1 outputs low", int'({smi_irq, sys_rst_out}), 0);

        // R4 start-value writes
        wr(18, 3);       rd(18, DEFI, "R4 value 3 ignored");
        wr(18, 0);       rd(18, DEFI, "R4 value 0 ignored");
        wr(18, 16'hFC05); rd(18, 5, "R4 upper bits read 0");

        // R3 halted counter holds
        repeat (20) @(negedge clk);
        rd(0, DEFI, "R3 frozen while halted");

        // R2 reload
        wr(0, 16'h1234); rd(0, 5, "R2 reload loads start value");

        // run with interrupt enabled
        wr(12, 16'h2000);
        wr(8, 0);
        n = 0;
        while (!smi_irq && n < 200) begin @(negedge clk); n++; end
        chk(smi_irq, "R6 interrupt on first expiry", int'(smi_irq), 1);
        rd(4, 8, "R6 timeout flag set");
        rd(0, 5, "R5 count reloaded after expiry");

        // R7 second expiry
        n = 0;
        while (!sys_rst_out && n < 200) begin @(negedge clk); n++; end
        hi = 0;
        while (sys_rst_out && hi < 50) begin hi++; @(negedge clk); end
        chk(hi == RSTN, "R7 reset pulse width", hi, RSTN);
        rd(6, 6, "R7 second and boot flags");

        // R8 write-one-to-clear
        wr(6, 2);  rd(6, 4, "R8 clears only second flag");
        wr(4, 0);  rd(4, 8, "R8 zero write keeps flag");
        wr(6, 4);  rd(6, 0, "R8 boot flag cleared");
        wr(4, 8);  rd(4, 0, "R8 timeout flag cleared");

        // R8 clear held across an expiry: set must win
        @(negedge clk); #0.2;
        bus_addr = 5'(4); bus_wdata = 16'h0008; bus_wr = 1'b1;
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (smi_irq) begin
                seen = 1;
                chk(bus_rdata[3], "R8 set wins over clear", int'(bus_rdata[3]), 1);
            end
        end
        #0.2 bus_wr = 1'b0;
        chk(seen, "R8 expiry during held clear", int'(seen), 1);

        // R9 keepalive right up to the expiring tick
        wr(0, 0);
        wr(4, 8);
        for (int k = 16; k <= 22; k++) begin
            repeat (k) @(negedge clk);
            wr(0, 0);
        end
        rd(4, 0, "R9 reload on tick prevents expiry");
        repeat (23) @(negedge clk);
        wr(0, 0);
        rd(4, 8, "R9 one cycle late expires");

        // R7 no_reboot blocks the pulse but flags still escalate
        @(negedge clk); #0.2 no_reboot = 1'b1;
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sys_rst_out) seen = 1;
        end
        chk(!seen, "R7 no_reboot blocks reset", int'(seen), 0);
        rd(6, 6, "R7 flags set with no_reboot");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule